// File: doc/BRIEF.md
# Transmit Descriptor Ring Fetcher

This block feeds a MAC transmit path from a ring of descriptors that software builds in memory. Software loads the ring start address while the fetcher is idle, fills descriptors, sets their owner bits and then writes a poll strobe. The fetcher reads the descriptor at its current position. If hardware owns it, the fetcher reads the control word and the buffer pointer, streams the buffer bytes out on a valid/ready byte interface, and writes the status word back with the owner bit cleared. It then moves on to the next descriptor. The scan stops at the first descriptor that software owns.

Each descriptor takes 16 bytes. Word 0 holds the owner flag and the status. Word 1 holds the frame length, the segment flags and the end-of-ring flag. Word 2 holds the buffer byte address. Word 3 is unused. Memory is reached through one request/grant port, and the same port serves reads and writes. A descriptor with a bad length or a bad buffer address is returned to software with an error status and no bytes are sent.

Top module: `txf_desc_fetch`

## Requirements
- R1: After reset, `cur_desc_addr` is 0, `busy` is low, and neither a memory request nor `tx_valid` is raised.
- R2: A `base_wr` pulse while the fetcher is idle loads both the ring start and `cur_desc_addr` with `base_wdata`, its low four bits cleared. A `base_wr` while `busy` is high changes neither of them.
- R3: A `poll_wr` pulse makes an idle fetcher read word 0 at `cur_desc_addr`. If bit 31 (owner) of that word is 0, the fetcher stops with no bytes sent, no memory write, and `cur_desc_addr` unchanged.
- R4: For an owned descriptor, the fetcher sends the number of bytes in word 1 bits [10:0], starting at the byte address in word 2. Byte k of a 32-bit memory word is bits [8k+7:8k]. `tx_first` marks the first byte when word 1 bit 29 is set. `tx_last` marks the final byte when word 1 bit 28 is set.
- R5: After a frame, word 0 of the descriptor is written to 0, so the owner bit is clear and no status bit is set. `cur_desc_addr` then advances by 16 and the scan continues.
- R6: After a descriptor with word 1 bit 31 (end of ring) set, the next descriptor read is at the ring start address.
- R7: A length below 60 sends no bytes. Word 0 is written with only bit 1 set, and the scan continues.
- R8: A buffer address with bit 0 set sends no bytes. Word 0 is written with only bit 0 set, and the scan continues. Addresses aligned to 2 or 4 bytes are valid.
- R9: A `poll_wr` that arrives while a scan is running is remembered. This includes a poll in the same cycle in which the scan reads a software-owned descriptor. The remembered poll causes one fresh read of the current descriptor after the scan stops.
- R10: A memory request keeps its address, direction and write data stable until `mem_gnt`. While `tx_ready` is low, `tx_valid` stays high and `tx_data`, `tx_first` and `tx_last` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| base_wr | input | 1 | Ring start address write strobe |
| base_wdata | input | ADDR_W | Ring start address |
| poll_wr | input | 1 | Poll-demand write strobe |
| cur_desc_addr | output | ADDR_W | Byte address of the current descriptor |
| busy | output | 1 | Scan active or poll pending |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | ADDR_W | Word-aligned byte address |
| mem_wdata | output | 32 | Write data |
| mem_gnt | input | 1 | Access accepted this cycle; read data valid |
| mem_rdata | input | 32 | Read data, valid with `mem_gnt` |
| tx_valid | output | 1 | Transmit byte valid |
| tx_ready | input | 1 | Transmit side takes the byte |
| tx_data | output | 8 | Transmit byte |
| tx_first | output | 1 | First byte of a frame segment |
| tx_last | output | 1 | Last byte of a frame segment |

## Verification
A poll strobe can land in the same cycle in which the scan finds a descriptor that software owns. In that cycle the scan stops and the new demand must be kept. The bench provokes this by raising `poll_wr` exactly in the cycle where it grants the read of an unowned word 0. In the next cycle it hands that descriptor to hardware. The case passes only if word 0 is read twice and the frame is then sent. Without the retained poll the fetcher would sit idle.

// File: rtl/txf_pkg.sv
package txf_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_OWN,
    ST_RD_CTL,
    ST_RD_BUF,
    ST_CHECK,
    ST_FETCH,
    ST_SEND,
    ST_WBACK
  } txf_state_e;

  // word 0
  localparam int OWN_BIT     = 31;
  localparam int ERR_LEN_BIT = 1;
  localparam int ERR_ALN_BIT = 0;
  // word 1
  localparam int EOR_BIT     = 31;
  localparam int FS_BIT      = 29;
  localparam int LS_BIT      = 28;

  localparam int DESC_BYTES  = 16;
  localparam int WORD_BYTES  = 4;

endpackage

// File: rtl/txf_rst_sync.sv
module txf_rst_sync (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_n_o = sync_q[1];

endmodule

// File: rtl/txf_ring_ptr.sv
module txf_ring_ptr #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic              advance,
  input  logic              wrap,
  output logic [ADDR_W-1:0] cur_q
);

  import txf_pkg::*;

  localparam int ALIGN_W = $clog2(DESC_BYTES);

  logic [ADDR_W-1:0] start_q, start_d, cur_d;
  logic [ADDR_W-1:0] load_aligned;

  assign load_aligned = {load_addr[ADDR_W-1:ALIGN_W], {ALIGN_W{1'b0}}};

  always_comb begin
    start_d = start_q;
    cur_d   = cur_q;
    if (load) begin
      start_d = load_aligned;
      cur_d   = load_aligned;
    end else if (advance) begin
      cur_d = wrap ? start_q : cur_q + ADDR_W'(DESC_BYTES);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
      cur_q   <= '0;
    end else begin
      start_q <= start_d;
      cur_q   <= cur_d;
    end
  end

endmodule

// File: rtl/txf_unpack.sv
module txf_unpack #(
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [LEN_W-1:0]  start_len,
  input  logic              word_ld,
  input  logic [31:0]       word_in,
  input  logic              take,
  output logic [7:0]        byte_o,
  output logic [ADDR_W-1:0] word_addr,
  output logic              first_o,
  output logic              last_o,
  output logic              word_end_o
);

  logic [ADDR_W-1:0] ptr_q, ptr_d;
  logic [LEN_W-1:0]  rem_q, rem_d;
  logic [31:0]       word_q, word_d;
  logic              first_q, first_d;

  always_comb begin
    ptr_d   = ptr_q;
    rem_d   = rem_q;
    first_d = first_q;
    word_d  = word_ld ? word_in : word_q;
    if (start) begin
      ptr_d   = start_addr;
      rem_d   = start_len;
      first_d = 1'b1;
    end else if (take) begin
      ptr_d   = ptr_q + ADDR_W'(1);
      rem_d   = rem_q - LEN_W'(1);
      first_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q   <= '0;
      rem_q   <= '0;
      word_q  <= '0;
      first_q <= 1'b0;
    end else begin
      ptr_q   <= ptr_d;
      rem_q   <= rem_d;
      word_q  <= word_d;
      first_q <= first_d;
    end
  end

  assign byte_o     = word_q[{ptr_q[1:0], 3'b000} +: 8];
  assign word_addr  = {ptr_q[ADDR_W-1:2], 2'b00};
  assign first_o    = first_q;
  assign last_o     = (rem_q == LEN_W'(1));
  assign word_end_o = (ptr_q[1:0] == 2'b11);

endmodule

// File: rtl/txf_ctrl.sv
module txf_ctrl #(
  parameter int ADDR_W  = 16,
  parameter int LEN_W   = 11,
  parameter int MIN_LEN = 60
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              poll_wr,
  input  logic              base_wr,
  input  logic              mem_gnt,
  input  logic [31:0]       mem_rdata,
  input  logic              tx_ready,
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic [ADDR_W-1:0] word_addr,
  input  logic              first_byte,
  input  logic              last_byte,
  input  logic              word_end,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  output logic              tx_valid,
  output logic              tx_first,
  output logic              tx_last,
  output logic              ptr_load,
  output logic              ptr_adv,
  output logic              ptr_wrap,
  output logic              un_start,
  output logic [ADDR_W-1:0] un_addr,
  output logic [LEN_W-1:0]  un_len,
  output logic              un_word_ld,
  output logic              un_take,
  output logic              busy
);

  import txf_pkg::*;

  txf_state_e        state_q, state_d;
  logic              pend_q, pend_d;
  logic [LEN_W-1:0]  len_q, len_d;
  logic              fs_q, fs_d, ls_q, ls_d, eor_q, eor_d;
  logic [ADDR_W-1:0] buf_q, buf_d;
  logic [1:0]        err_q, err_d;
  logic              idle;

  assign idle = (state_q == ST_IDLE);

  always_comb begin
    state_d    = state_q;
    len_d      = len_q;
    fs_d       = fs_q;
    ls_d       = ls_q;
    eor_d      = eor_q;
    buf_d      = buf_q;
    err_d      = err_q;
    mem_req    = 1'b0;
    mem_we     = 1'b0;
    mem_addr   = cur_addr;
    mem_wdata  = '0;
    tx_valid   = 1'b0;
    tx_first   = 1'b0;
    tx_last    = 1'b0;
    ptr_adv    = 1'b0;
    ptr_wrap   = 1'b0;
    un_start   = 1'b0;
    un_word_ld = 1'b0;
    un_take    = 1'b0;
    pend_d     = poll_wr | (pend_q & !idle);
    unique case (state_q)
      ST_IDLE: begin
        if (pend_q) state_d = ST_RD_OWN;
      end
      ST_RD_OWN: begin
        mem_req = 1'b1;
        if (mem_gnt) state_d = mem_rdata[OWN_BIT] ? ST_RD_CTL : ST_IDLE;
      end
      ST_RD_CTL: begin
        mem_req  = 1'b1;
        mem_addr = cur_addr + ADDR_W'(WORD_BYTES);
        if (mem_gnt) begin
          len_d   = mem_rdata[LEN_W-1:0];
          fs_d    = mem_rdata[FS_BIT];
          ls_d    = mem_rdata[LS_BIT];
          eor_d   = mem_rdata[EOR_BIT];
          state_d = ST_RD_BUF;
        end
      end
      ST_RD_BUF: begin
        mem_req  = 1'b1;
        mem_addr = cur_addr + ADDR_W'(2 * WORD_BYTES);
        if (mem_gnt) begin
          buf_d   = mem_rdata[ADDR_W-1:0];
          state_d = ST_CHECK;
        end
      end
      ST_CHECK: begin
        err_d = '0;
        err_d[ERR_LEN_BIT] = (len_q < LEN_W'(MIN_LEN));
        err_d[ERR_ALN_BIT] = buf_q[0];
        if (err_d != 2'b00) begin
          state_d = ST_WBACK;
        end else begin
          un_start = 1'b1;
          state_d  = ST_FETCH;
        end
      end
      ST_FETCH: begin
        mem_req  = 1'b1;
        mem_addr = word_addr;
        if (mem_gnt) begin
          un_word_ld = 1'b1;
          state_d    = ST_SEND;
        end
      end
      ST_SEND: begin
        tx_valid = 1'b1;
        tx_first = first_byte & fs_q;
        tx_last  = last_byte & ls_q;
        if (tx_ready) begin
          un_take = 1'b1;
          if (last_byte)     state_d = ST_WBACK;
          else if (word_end) state_d = ST_FETCH;
        end
      end
      ST_WBACK: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_wdata = {30'b0, err_q};
        if (mem_gnt) begin
          ptr_adv  = 1'b1;
          ptr_wrap = eor_q;
          state_d  = ST_RD_OWN;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pend_q  <= 1'b0;
      len_q   <= '0;
      fs_q    <= 1'b0;
      ls_q    <= 1'b0;
      eor_q   <= 1'b0;
      buf_q   <= '0;
      err_q   <= '0;
    end else begin
      state_q <= state_d;
      pend_q  <= pend_d;
      len_q   <= len_d;
      fs_q    <= fs_d;
      ls_q    <= ls_d;
      eor_q   <= eor_d;
      buf_q   <= buf_d;
      err_q   <= err_d;
    end
  end

  assign ptr_load = base_wr & idle & !pend_q;
  assign un_addr  = buf_q;
  assign un_len   = len_q;
  assign busy     = pend_q | !idle;

endmodule

// File: rtl/txf_desc_fetch.sv
module txf_desc_fetch #(
  parameter int ADDR_W  = 16,
  parameter int LEN_W   = 11,
  parameter int MIN_LEN = 60
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              base_wr,
  input  logic [ADDR_W-1:0] base_wdata,
  input  logic              poll_wr,
  output logic [ADDR_W-1:0] cur_desc_addr,
  output logic              busy,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_gnt,
  input  logic [31:0]       mem_rdata,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [7:0]        tx_data,
  output logic              tx_first,
  output logic              tx_last
);

  logic              rst_sn;
  logic              ptr_load, ptr_adv, ptr_wrap;
  logic              un_start, un_word_ld, un_take;
  logic [ADDR_W-1:0] un_addr, word_addr;
  logic [LEN_W-1:0]  un_len;
  logic              first_byte, last_byte, word_end;

  txf_rst_sync u_rst (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_sn)
  );

  txf_ring_ptr #(.ADDR_W(ADDR_W)) u_ptr (
    .clk       (clk),
    .rst_n     (rst_sn),
    .load      (ptr_load),
    .load_addr (base_wdata),
    .advance   (ptr_adv),
    .wrap      (ptr_wrap),
    .cur_q     (cur_desc_addr)
  );

  txf_unpack #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_unpack (
    .clk        (clk),
    .rst_n      (rst_sn),
    .start      (un_start),
    .start_addr (un_addr),
    .start_len  (un_len),
    .word_ld    (un_word_ld),
    .word_in    (mem_rdata),
    .take       (un_take),
    .byte_o     (tx_data),
    .word_addr  (word_addr),
    .first_o    (first_byte),
    .last_o     (last_byte),
    .word_end_o (word_end)
  );

  txf_ctrl #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .MIN_LEN(MIN_LEN)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_sn),
    .poll_wr    (poll_wr),
    .base_wr    (base_wr),
    .mem_gnt    (mem_gnt),
    .mem_rdata  (mem_rdata),
    .tx_ready   (tx_ready),
    .cur_addr   (cur_desc_addr),
    .word_addr  (word_addr),
    .first_byte (first_byte),
    .last_byte  (last_byte),
    .word_end   (word_end),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .tx_valid   (tx_valid),
    .tx_first   (tx_first),
    .tx_last    (tx_last),
    .ptr_load   (ptr_load),
    .ptr_adv    (ptr_adv),
    .ptr_wrap   (ptr_wrap),
    .un_start   (un_start),
    .un_addr    (un_addr),
    .un_len     (un_len),
    .un_word_ld (un_word_ld),
    .un_take    (un_take),
    .busy       (busy)
  );

endmodule

// File: rtl/txf_desc_fetch_chk.sv
module txf_desc_fetch_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              poll_wr,
  input logic [ADDR_W-1:0] cur_desc_addr,
  input logic              busy,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [31:0]       mem_wdata,
  input logic              mem_gnt,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic [7:0]        tx_data,
  input logic              tx_first,
  input logic              tx_last
);

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_req && !tx_valid));

  p_desc_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cur_desc_addr[3:0] == 4'h0);

  p_poll_taken_r9: assert property (@(posedge clk) disable iff (!rst_n)
    poll_wr |=> busy);

  p_no_overlap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_valid && mem_req));

  p_marks_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_first || tx_last) |-> tx_valid);

  p_wb_owner_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (mem_wdata[31:2] == 30'h0));

  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                               && $stable(mem_wdata)));

  p_tx_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)
                                 && $stable(tx_first) && $stable(tx_last)));

endmodule

bind txf_desc_fetch txf_desc_fetch_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .poll_wr       (poll_wr),
  .cur_desc_addr (cur_desc_addr),
  .busy          (busy),
  .mem_req       (mem_req),
  .mem_we        (mem_we),
  .mem_addr      (mem_addr),
  .mem_wdata     (mem_wdata),
  .mem_gnt       (mem_gnt),
  .tx_valid      (tx_valid),
  .tx_ready      (tx_ready),
  .tx_data       (tx_data),
  .tx_first      (tx_first),
  .tx_last       (tx_last)
);

// File: tb/sim_txf_desc_fetch.sv
`timescale 1ns/1ps
module sim_txf_desc_fetch;

  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          base_wr, poll_wr;
  logic [AW-1:0] base_wdata;
  logic [AW-1:0] cur_desc_addr;
  logic          busy;
  logic          mem_req, mem_we, mem_gnt;
  logic [AW-1:0] mem_addr;
  logic [31:0]   mem_wdata, mem_rdata;
  logic          tx_valid, tx_ready, tx_first, tx_last;
  logic [7:0]    tx_data;

  logic [31:0]   mem [0:255];
  logic          bd_we;
  logic [AW-1:0] bd_addr;
  logic [31:0]   bd_data;
  int            gnt_delay, wcnt, rcyc;
  bit            rdy_slow;
  logic [AW-1:0] watch_addr;
  int            own_reads, wb_cnt, ncap, hold_err;
  logic [7:0]    cap_d [0:1023];
  logic          cap_f [0:1023];
  logic          cap_l [0:1023];
  logic          prev_stall;
  logic [9:0]    prev_tx;
  int            nchk, nfail;
  bit            timed_out;

  always #4 clk = ~clk;

  txf_desc_fetch #(.ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .base_wr(base_wr), .base_wdata(base_wdata),
    .poll_wr(poll_wr), .cur_desc_addr(cur_desc_addr), .busy(busy),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .mem_rdata(mem_rdata),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .tx_first(tx_first), .tx_last(tx_last));

  assign mem_rdata = mem[mem_addr[9:2]];

  function automatic logic [7:0] pat(int a);
    return 8'((a * 13 + 5) & 255);
  endfunction

  // grant and ready model
  always @(negedge clk) begin
    rcyc = rcyc + 1;
    tx_ready = rdy_slow ? (rcyc % 3 != 0) : 1'b1;
    if (mem_gnt) begin
      mem_gnt = 1'b0;
      wcnt = 0;
    end else if (mem_req) begin
      if (wcnt >= gnt_delay) mem_gnt = 1'b1;
      else wcnt = wcnt + 1;
    end else begin
      wcnt = 0;
    end
  end

  // memory, capture and monitors
  always @(posedge clk) begin
    if (mem_req && mem_gnt && !mem_we && mem_addr == watch_addr) own_reads = own_reads + 1;
    if (mem_req && mem_gnt && mem_we) begin
      mem[mem_addr[9:2]] = mem_wdata;
      wb_cnt = wb_cnt + 1;
    end
    if (bd_we) mem[bd_addr[9:2]] = bd_data;
    if (prev_stall && (!tx_valid || {tx_data, tx_first, tx_last} != prev_tx))
      hold_err = hold_err + 1;
    prev_stall = tx_valid && !tx_ready;
    prev_tx = {tx_data, tx_first, tx_last};
    if (tx_valid && tx_ready && ncap < 1024) begin
      cap_d[ncap] = tx_data;
      cap_f[ncap] = tx_first;
      cap_l[ncap] = tx_last;
      ncap = ncap + 1;
    end
  end

  task automatic chk(string req, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic poke(int a, logic [31:0] d);
    bd_addr = AW'(a);
    bd_data = d;
    bd_we = 1'b1;
    @(posedge clk); #1;
    bd_we = 1'b0;
  endtask

  task automatic set_desc(int a, bit own, bit eor, bit fs, bit ls, int len, int bufa);
    poke(a + 4, {eor, 1'b0, fs, ls, 17'h0, 11'(len)});
    poke(a + 8, 32'(bufa));
    poke(a + 12, 32'h0);
    poke(a, {own, 31'h0});
  endtask

  task automatic poll();
    @(posedge clk); #1 poll_wr = 1'b1;
    @(posedge clk); #1 poll_wr = 1'b0;
  endtask

  task automatic wait_idle();
    repeat (3) @(posedge clk);
    for (int i = 0; i < 5000 && busy; i++) @(posedge clk);
    #1;
  endtask

  task automatic check_frame(string req, int start, int bufa, int len, bit fs, bit ls);
    int bad = 0;
    int fl = 0;
    for (int i = 0; i < len; i++) begin
      if (cap_d[start + i] != pat(bufa + i)) bad++;
      if (cap_f[start + i] != (fs && i == 0)) fl++;
      if (cap_l[start + i] != (ls && i == len - 1)) fl++;
    end
    chk({req, " byte mismatches"}, bad, 0);
    chk({req, " first/last marks wrong"}, fl, 0);
  endtask

  task automatic t_reset();
    chk("R1 cur_desc_addr", int'(cur_desc_addr), 0);
    chk("R1 busy", int'(busy), 0);
    chk("R1 mem_req/tx_valid", int'({mem_req, tx_valid}), 0);
  endtask

  task automatic t_base();
    @(posedge clk); #1 base_wr = 1'b1; base_wdata = 16'h010F;
    @(posedge clk); #1 base_wr = 1'b0;
    chk("R2 base load aligned", int'(cur_desc_addr), 'h100);
  endtask

  task automatic t_empty();
    int r0 = own_reads, w0 = wb_cnt, c0 = ncap;
    watch_addr = 16'h0100;
    poll(); wait_idle();
    chk("R3 word0 reads", own_reads - r0, 1);
    chk("R3 no bytes", ncap - c0, 0);
    chk("R3 no writeback", wb_cnt - w0, 0);
    chk("R3 cur unchanged", int'(cur_desc_addr), 'h100);
  endtask

  task automatic t_single();
    int c0 = ncap;
    gnt_delay = 2; rdy_slow = 1'b1;
    set_desc('h100, 1, 0, 1, 1, 64, 'h202);
    poll(); wait_idle();
    chk("R4 byte count", ncap - c0, 64);
    check_frame("R4", c0, 'h202, 64, 1, 1);
    chk("R5 word0 cleared", int'(mem['h40]), 0);
    chk("R5 cur advanced", int'(cur_desc_addr), 'h110);
    chk("R10 tx hold under stall", hold_err, 0);
  endtask

  task automatic t_wrap();
    int c0 = ncap;
    gnt_delay = 0; rdy_slow = 1'b0;
    set_desc('h110, 1, 1, 1, 1, 61, 'h280);
    set_desc('h100, 1, 0, 1, 1, 60, 'h2C2);
    poll(); wait_idle();
    chk("R6 total bytes", ncap - c0, 121);
    check_frame("R6 ring end frame", c0, 'h280, 61, 1, 1);
    check_frame("R6 wrapped frame", c0 + 61, 'h2C2, 60, 1, 1);
    chk("R6 stop position", int'(cur_desc_addr), 'h110);
  endtask

  task automatic t_len_err();
    int c0 = ncap;
    set_desc('h110, 1, 1, 1, 1, 59, 'h300);
    poll(); wait_idle();
    chk("R7 no bytes", ncap - c0, 0);
    chk("R7 status word", int'(mem['h44]), 2);
    chk("R7 scan continued", int'(cur_desc_addr), 'h100);
  endtask

  task automatic t_align_err();
    int c0 = ncap;
    set_desc('h100, 1, 0, 1, 1, 70, 'h301);
    poll(); wait_idle();
    chk("R8 no bytes", ncap - c0, 0);
    chk("R8 status word", int'(mem['h40]), 1);
    chk("R8 scan continued", int'(cur_desc_addr), 'h110);
  endtask

  task automatic t_flags();
    int c0 = ncap;
    rdy_slow = 1'b1; gnt_delay = 1;
    set_desc('h110, 1, 1, 1, 0, 62, 'h340);
    set_desc('h100, 1, 0, 0, 1, 63, 'h382);
    poll(); wait_idle();
    chk("R4 segment bytes", ncap - c0, 125);
    check_frame("R4 first-only segment", c0, 'h340, 62, 1, 0);
    check_frame("R4 last-only segment", c0 + 62, 'h382, 63, 0, 1);
  endtask

  task automatic t_poll_stop();
    int r0, c0;
    rdy_slow = 1'b0; gnt_delay = 1;
    poke('h114, {1'b1, 2'b01, 1'b1, 17'h0, 11'd60});
    poke('h118, 32'h0000_0240);
    watch_addr = 16'h0110;
    r0 = own_reads; c0 = ncap;
    poll();
    for (int i = 0; i < 200; i++) begin
      @(negedge clk); #1;
      if (mem_gnt && mem_req && !mem_we && mem_addr == 16'h0110) break;
    end
    poll_wr = 1'b1;
    @(posedge clk); #1 poll_wr = 1'b0;
    poke('h110, 32'h8000_0000);
    wait_idle();
    chk("R9 word0 re-read", own_reads - r0, 2);
    chk("R9 frame after retained poll", ncap - c0, 60);
    chk("R9 final position", int'(cur_desc_addr), 'h100);
  endtask

  task automatic t_base_busy();
    int c0;
    rdy_slow = 1'b1;
    set_desc('h100, 1, 0, 1, 1, 64, 'h200);
    poll();
    for (int i = 0; i < 200 && !tx_valid; i++) @(posedge clk);
    #1 base_wr = 1'b1; base_wdata = 16'h0180;
    @(posedge clk); #1 base_wr = 1'b0;
    chk("R2 cur kept while busy", int'(cur_desc_addr), 'h100);
    wait_idle();
    chk("R2 cur after frame", int'(cur_desc_addr), 'h110);
    c0 = ncap;
    set_desc('h110, 1, 1, 1, 1, 60, 'h200);
    poll(); wait_idle();
    chk("R2 wrap to old start", int'(cur_desc_addr), 'h100);
    chk("R2 frame sent", ncap - c0, 60);
  endtask

  initial begin
    rst_n = 1'b0; base_wr = 1'b0; poll_wr = 1'b0; base_wdata = '0;
    bd_we = 1'b0; bd_addr = '0; bd_data = '0;
    gnt_delay = 0; wcnt = 0; rcyc = 0; rdy_slow = 1'b0;
    mem_gnt = 1'b0; tx_ready = 1'b1;
    watch_addr = '0; own_reads = 0; wb_cnt = 0; ncap = 0; hold_err = 0;
    prev_stall = 1'b0; prev_tx = '0;
    nchk = 0; nfail = 0; timed_out = 1'b0;
    for (int w = 0; w < 256; w++) begin
      if (w >= 'h40 && w < 'h80) poke(w * 4, 32'h0);
      else poke(w * 4, {pat(w*4+3), pat(w*4+2), pat(w*4+1), pat(w*4)});
    end
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk); #1;
    fork
      begin
        t_reset();
        t_base();
        t_empty();
        t_single();
        t_wrap();
        t_len_err();
        t_align_err();
        t_flags();
        t_poll_stop();
        t_base_busy();
      end
      begin
        repeat (150000) @(posedge clk);
        timed_out = 1'b1;
      end
    join_any
    disable fork;
    if (timed_out) begin
      nchk++; nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    $finish;
  end

endmodule